// File: doc/BRIEF.md
# Dual Byte FIFO with Trigger-Level Interrupts

This block sits between a serial-peripheral shift engine and the software that feeds it. It keeps one byte queue per direction: software writes outgoing bytes into the transmit queue, and the engine pops them. The engine pushes incoming bytes into the receive queue, and software pops them by reading a data address. A small word-addressed register port carries control, occupancy and interrupt state.

Each direction has its own programmable trigger level. When the receive queue holds at least its level, the block raises a ready indication. When the transmit queue has drained to its level or below, the block raises a refill indication. Both indications feed a latched interrupt status and, when enabled, a per-direction DMA request line.

The interrupt status also latches receive overflow and an end-of-transfer pulse from the engine. Software clears a status bit by writing 1 to it. A bit whose condition still holds is set again on the next cycle. Each queue can be flushed through a flush bit that clears itself.

Top module: `dual_fifo_irq`

## Requirements
- R1: A register write to address 4 appends bits 7:0 of the write data to the transmit queue, unless the queue is full, in which case the byte is dropped. `tx_data_o` shows the oldest byte. `tx_pop_i` removes that byte and has no effect on an empty queue. `tx_empty_o` is high when the transmit queue holds 0 bytes.
- R2: `rx_push_i` appends `rx_data_i` to the receive queue. A read strobe at address 5 returns the oldest receive byte in bits 7:0 of `reg_rdata_o` and removes it. Such a read has no effect on an empty queue. `rx_full_o` is high when the receive queue holds DEPTH bytes.
- R3: Address 1 reads the receive byte count in bits 7:0 and the transmit byte count in bits 23:16. All other bits read zero.
- R4: Address 0 is the queue control word. Its fields are: receive trigger level in bits 7:0, receive DMA enable at bit 8, receive flush at bit 15, transmit trigger level in bits 23:16, transmit DMA enable at bit 24 and transmit flush at bit 31. It resets to zero.
- R5: A flush bit written as 1 reads back 1 for one cycle. On the following edge the matching queue is emptied, and any push or pop in that cycle is discarded. From then on the bit reads 0.
- R6: Status bits are set one cycle after their condition:
  - bit 0 (receive ready): receive count is nonzero and at least the receive trigger level.
  - bit 4 (transmit refill): transmit count is at most the transmit trigger level.
  - bit 8 (overflow): `rx_push_i` arrives while the receive queue is full. The byte is dropped.
  - bit 12 (done): `xfer_done_i` is high.
- R7: Address 3 reads the status. Writing it clears each bit written as 1, and all ones clears every bit. A bit whose condition holds in the clearing cycle stays set.
- R8: Address 2 holds interrupt enables in the same bit layout as the status, and resets to zero. `irq_o` is high when any status bit and its enable are both set.
- R9: `rx_dreq_o` is high when the receive DMA enable is set and the receive count is nonzero and at least the receive trigger level. `tx_dreq_o` is high when the transmit DMA enable is set and the transmit count is below DEPTH and at most the transmit trigger level. Both follow the current counts with no delay.
- R10: DEPTH is a power of two of at most 128 (64 by default). A queue holds exactly DEPTH bytes, and its count never exceeds DEPTH.

Reads of addresses 6 and 7 return zero. Writes to addresses 1, 5, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops at address 5) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| tx_pop_i | input | 1 | Engine removes transmit head |
| tx_data_o | output | 8 | Transmit head byte |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_push_i | input | 1 | Engine appends a receive byte |
| rx_data_i | input | 8 | Receive byte from engine |
| rx_full_o | output | 1 | Receive queue full |
| xfer_done_i | input | 1 | Transfer-complete pulse from engine |
| tx_dreq_o | output | 1 | Transmit DMA request |
| rx_dreq_o | output | 1 | Receive DMA request |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle:
- a queue count never exceeds DEPTH;
- a flush empties its queue on the next edge;
- a push into a full queue leaves the count unchanged;
- a flush bit never survives two cycles unless it is rewritten;
- a status bit stays set until a clear is written, and any set condition latches.

Only the bench scenarios can show three further behaviours. The first is that the queues keep byte order through wrap-around. The second is that a clear written while a trigger condition still holds is undone in the next cycle. The third is that the register fields sit at the stated bit positions. The bench shows these by comparing all outputs each cycle against a queue-based model, under directed and randomised traffic.

// File: rtl/dfi_pkg.sv
package dfi_pkg;
  localparam int unsigned AddrW = 3;

  localparam logic [AddrW-1:0] A_FCTL = 3'd0;
  localparam logic [AddrW-1:0] A_FSTA = 3'd1;
  localparam logic [AddrW-1:0] A_IEN  = 3'd2;
  localparam logic [AddrW-1:0] A_ISTA = 3'd3;
  localparam logic [AddrW-1:0] A_TXD  = 3'd4;
  localparam logic [AddrW-1:0] A_RXD  = 3'd5;

  localparam int unsigned NIRQ = 4;
  // compact index of each interrupt source
  localparam int unsigned I_RDY  = 0;
  localparam int unsigned I_TREQ = 1;
  localparam int unsigned I_OVF  = 2;
  localparam int unsigned I_DONE = 3;

  typedef struct packed {
    logic       tx_flush;
    logic       tx_den;
    logic [7:0] tx_trig;
    logic       rx_flush;
    logic       rx_den;
    logic [7:0] rx_trig;
  } fctl_t;

  // interrupt bits live at word positions 0, 4, 8, 12
  function automatic logic [31:0] irq_pack(logic [NIRQ-1:0] v);
    return {19'b0, v[3], 3'b0, v[2], 3'b0, v[1], 3'b0, v[0]};
  endfunction

  function automatic logic [NIRQ-1:0] irq_unpack(logic [31:0] w);
    return {w[12], w[8], w[4], w[0]};
  endfunction
endpackage

// File: rtl/dfi_byte_fifo.sv
module dfi_byte_fifo #(
  parameter int unsigned DEPTH = 64
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic                           push_i,
  input  logic [7:0]                     data_i,
  input  logic                           pop_i,
  output logic [7:0]                     head_o,
  output logic [$clog2(DEPTH+1)-1:0]     count_o,
  output logic                           full_o,
  output logic                           empty_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH)); // R10
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0)); // R5
  AST_FULL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(count_o)); // R1
endmodule

// File: rtl/dfi_irq_unit.sv
module dfi_irq_unit #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[i] <= 1'b0;
      else         stat_q[i] <= (stat_q[i] && !clr_i[i]) || set_i[i];
    end

    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[i] && !clr_i[i]) |=> stat_q[i]); // R7
    AST_SET_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> stat_q[i]); // R6
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);
endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
  import dfi_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [AddrW-1:0]  reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              tx_pop_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_empty_o,
  input  logic              rx_push_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_full_o,
  input  logic              xfer_done_i,
  output logic              tx_dreq_o,
  output logic              rx_dreq_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  fctl_t            fctl_q;
  logic [NIRQ-1:0]  ien_q, stat, set_v, clr_v;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [7:0]       tx_cnt8, rx_cnt8, rx_head;
  logic             tx_full, rx_empty;
  logic             wr_fctl, wr_ien, wr_ista, wr_txd, rd_rxd;
  logic             rx_rdy_c, tx_req_c;
  logic             unused_wbits;

  assign wr_fctl = reg_we_i && (reg_addr_i == A_FCTL);
  assign wr_ien  = reg_we_i && (reg_addr_i == A_IEN);
  assign wr_ista = reg_we_i && (reg_addr_i == A_ISTA);
  assign wr_txd  = reg_we_i && (reg_addr_i == A_TXD);
  assign rd_rxd  = reg_re_i && (reg_addr_i == A_RXD);
  assign unused_wbits = ^{reg_wdata_i[30:25], reg_wdata_i[14:9]};

  // control word; flush bits live one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fctl_q <= '0;
    end else if (wr_fctl) begin
      fctl_q.tx_flush <= reg_wdata_i[31];
      fctl_q.tx_den   <= reg_wdata_i[24];
      fctl_q.tx_trig  <= reg_wdata_i[23:16];
      fctl_q.rx_flush <= reg_wdata_i[15];
      fctl_q.rx_den   <= reg_wdata_i[8];
      fctl_q.rx_trig  <= reg_wdata_i[7:0];
    end else begin
      fctl_q.tx_flush <= 1'b0;
      fctl_q.rx_flush <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '0;
    else if (wr_ien) ien_q <= irq_unpack(reg_wdata_i);
  end

  dfi_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (fctl_q.tx_flush),
    .push_i  (wr_txd),
    .data_i  (reg_wdata_i[7:0]),
    .pop_i   (tx_pop_i),
    .head_o  (tx_data_o),
    .count_o (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty_o)
  );

  dfi_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (fctl_q.rx_flush),
    .push_i  (rx_push_i),
    .data_i  (rx_data_i),
    .pop_i   (rd_rxd),
    .head_o  (rx_head),
    .count_o (rx_cnt),
    .full_o  (rx_full_o),
    .empty_o (rx_empty)
  );

  assign tx_cnt8  = 8'(tx_cnt);
  assign rx_cnt8  = 8'(rx_cnt);
  assign rx_rdy_c = !rx_empty && (rx_cnt8 >= fctl_q.rx_trig);
  assign tx_req_c = (tx_cnt8 <= fctl_q.tx_trig);

  always_comb begin
    set_v         = '0;
    set_v[I_RDY]  = rx_rdy_c;
    set_v[I_TREQ] = tx_req_c;
    set_v[I_OVF]  = rx_push_i && rx_full_o;
    set_v[I_DONE] = xfer_done_i;
    clr_v         = wr_ista ? irq_unpack(reg_wdata_i) : '0;
  end

  dfi_irq_unit #(.N(NIRQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .en_i   (ien_q),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  assign rx_dreq_o = fctl_q.rx_den && rx_rdy_c;
  assign tx_dreq_o = fctl_q.tx_den && tx_req_c && !tx_full;

  always_comb begin
    unique case (reg_addr_i)
      A_FCTL:  reg_rdata_o = {fctl_q.tx_flush, 6'b0, fctl_q.tx_den, fctl_q.tx_trig,
                               fctl_q.rx_flush, 6'b0, fctl_q.rx_den, fctl_q.rx_trig};
      A_FSTA:  reg_rdata_o = {8'b0, tx_cnt8, 8'b0, rx_cnt8};
      A_IEN:   reg_rdata_o = irq_pack(ien_q);
      A_ISTA:  reg_rdata_o = irq_pack(stat);
      A_RXD:   reg_rdata_o = {24'b0, rx_head};
      default: reg_rdata_o = '0;
    endcase
  end

  AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fctl_q.rx_flush && !wr_fctl) |=> !fctl_q.rx_flush); // R5
  AST_RX_DREQ_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dreq_o |-> (rx_cnt != '0)); // R9
  AST_TX_DREQ_NOT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dreq_o |-> !tx_full); // R9
endmodule

// File: tb/dual_fifo_irq_test.sv
module dual_fifo_irq_test;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 0, reg_re = 0, tx_pop = 0, rx_push = 0, xfer_done = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [7:0]  rx_data = 0;
  logic [31:0] reg_rdata;
  logic [7:0]  tx_data;
  logic        tx_empty, rx_full, tx_dreq, rx_dreq, irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_fifo_irq #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .tx_empty_o(tx_empty),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_full_o(rx_full),
    .xfer_done_i(xfer_done), .tx_dreq_o(tx_dreq), .rx_dreq_o(rx_dreq), .irq_o(irq)
  );

  // reference model
  byte unsigned txq[$], rxq[$];
  int  m_rxtrig, m_txtrig;
  bit  m_rxden, m_txden, m_rxfl, m_txfl;
  bit [3:0] m_en, m_st;
  int  tc, rc;
  bit [3:0] setv, clrv;

  function automatic logic [31:0] pk(bit [3:0] v);
    return {19'b0, v[3], 3'b0, v[2], 3'b0, v[1], 3'b0, v[0]};
  endfunction

  function automatic bit rdy_c();
    return rxq.size() != 0 && rxq.size() >= m_rxtrig;
  endfunction

  function automatic bit treq_c();
    return txq.size() <= m_txtrig;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_rxtrig = 0; m_txtrig = 0; m_rxden = 0; m_txden = 0;
      m_rxfl = 0; m_txfl = 0; m_en = 0; m_st = 0;
    end else begin
      tc = txq.size(); rc = rxq.size();
      setv = {xfer_done, rx_push && rc == DEPTH, treq_c(), rdy_c()};
      clrv = (reg_we && reg_addr == 3) ? {reg_wdata[12], reg_wdata[8], reg_wdata[4], reg_wdata[0]} : 4'b0;
      m_st = (m_st & ~clrv) | setv;
      if (m_txfl) txq.delete();
      else begin
        if (tx_pop && tc != 0) void'(txq.pop_front());
        if (reg_we && reg_addr == 4 && tc != DEPTH) txq.push_back(reg_wdata[7:0]);
      end
      if (m_rxfl) rxq.delete();
      else begin
        if (reg_re && reg_addr == 5 && rc != 0) void'(rxq.pop_front());
        if (rx_push && rc != DEPTH) rxq.push_back(rx_data);
      end
      if (reg_we && reg_addr == 2) m_en = {reg_wdata[12], reg_wdata[8], reg_wdata[4], reg_wdata[0]};
      if (reg_we && reg_addr == 0) begin
        m_txfl = reg_wdata[31]; m_txden = reg_wdata[24]; m_txtrig = reg_wdata[23:16];
        m_rxfl = reg_wdata[15]; m_rxden = reg_wdata[8];  m_rxtrig = reg_wdata[7:0];
      end else begin
        m_txfl = 0; m_rxfl = 0;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata();
    case (reg_addr)
      3'd0: return {m_txfl, 6'b0, m_txden, 8'(m_txtrig), m_rxfl, 6'b0, m_rxden, 8'(m_rxtrig)};
      3'd1: return {8'b0, 8'(txq.size()), 8'b0, 8'(rxq.size())};
      3'd2: return pk(m_en);
      3'd3: return pk(m_st);
      3'd5: return {24'b0, rxq[0]};
      default: return 32'b0;
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      chk("R1 tx_empty", tx_empty, txq.size() == 0);
      if (txq.size() != 0) chk("R1 tx_data", tx_data, txq[0]);
      chk("R2 rx_full", rx_full, rxq.size() == DEPTH);
      if (!(reg_addr == 5 && rxq.size() == 0))
        chk($sformatf("R3 R4 R7 rdata@%0d", reg_addr), reg_rdata, exp_rdata());
      chk("R8 irq", irq, |(m_st & m_en));
      chk("R9 rx_dreq", rx_dreq, m_rxden && rdy_c());
      chk("R9 tx_dreq", tx_dreq, m_txden && treq_c() && txq.size() != DEPTH);
    end
  end

  task automatic drv(bit we, bit re, int addr, logic [31:0] wd,
                     bit pop, bit push, byte unsigned pd, bit done);
    reg_we = we; reg_re = re; reg_addr = 3'(addr); reg_wdata = wd;
    tx_pop = pop; rx_push = push; rx_data = pd; xfer_done = done;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    drv(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // drive an address and check its read data in the same cycle
  task automatic peek(int addr, logic [31:0] mask, logic [31:0] exp, string tag);
    reg_we = 0; reg_re = 0; reg_addr = 3'(addr); tx_pop = 0; rx_push = 0; xfer_done = 0;
    @(negedge clk);
    chk(tag, reg_rdata & mask, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 reset ctrl", reg_rdata, 32'h0);
    chk("R1 reset tx_empty", tx_empty, 1'b1);
    chk("R8 reset irq", irq, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(); idle();
    peek(3, 32'hFFFF_FFFF, 32'h10, "R6 tx refill after reset");

    drv(1, 0, 0, 32'h0101_0103, 0, 0, 0, 0);
    peek(0, 32'hFFFF_FFFF, 32'h0101_0103, "R4 ctrl readback");
    drv(1, 0, 4, 32'hA1, 0, 0, 0, 0);
    drv(1, 0, 4, 32'hB2, 0, 0, 0, 0);
    drv(1, 0, 4, 32'hC3, 0, 0, 0, 0);
    peek(1, 32'hFFFF_FFFF, 32'h0003_0000, "R3 tx count");
    chk("R1 tx head", tx_data, 8'hA1);
    drv(1, 0, 3, 32'h10, 0, 0, 0, 0);
    peek(3, 32'hFFFF_FFFF, 32'h0, "R7 clear refill");

    drv(0, 0, 0, 0, 0, 1, 8'h11, 0);
    drv(0, 0, 0, 0, 0, 1, 8'h22, 0);
    drv(0, 0, 0, 0, 0, 1, 8'h33, 0);
    chk("R9 rx dreq at level", rx_dreq, 1'b1);
    idle();
    peek(3, 32'hFFFF_FFFF, 32'h1, "R6 rx ready");
    drv(1, 0, 3, 32'h1, 0, 0, 0, 0);
    peek(3, 32'hFFFF_FFFF, 32'h1, "R7 clear while level holds");
    reg_addr = 5; reg_re = 1; reg_we = 0;
    @(negedge clk); chk("R2 rx head read", reg_rdata, 32'h11);
    @(posedge clk); #1;
    drv(1, 0, 2, 32'h1, 0, 0, 0, 0);
    @(negedge clk); chk("R8 irq enabled", irq, 1'b1);
    @(posedge clk); #1;
    drv(1, 0, 3, 32'hFFFF_FFFF, 0, 0, 0, 0);
    @(negedge clk); chk("R7 clear all", irq, 1'b0);
    @(posedge clk); #1;

    drv(1, 0, 0, 32'h8101_0103, 0, 0, 0, 0);
    peek(0, 32'hFFFF_FFFF, 32'h8101_0103, "R5 flush bit visible");
    peek(0, 32'hFFFF_FFFF, 32'h0101_0103, "R5 flush bit cleared");
    peek(1, 32'hFFFF_FFFF, 32'h0000_0002, "R5 tx flushed");

    for (int i = 0; i < DEPTH - 2; i++) drv(0, 0, 0, 0, 0, 1, 8'(i + 64), 0);
    chk("R10 rx full", rx_full, 1'b1);
    drv(0, 0, 0, 0, 0, 1, 8'hEE, 0);
    peek(3, 32'h100, 32'h100, "R6 overflow latched");
    peek(1, 32'hFF, 32'h40, "R10 count capped");
    drv(0, 0, 0, 0, 0, 0, 0, 1);
    peek(3, 32'h1000, 32'h1000, "R6 done latched");

    // randomised traffic: fill phase then drain phase
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 800; i++) begin
        int a = $urandom_range(0, 5);
        bit we = ($urandom_range(0, 3) == 0);
        logic [31:0] wd = $urandom;
        if (a == 0) wd = {($urandom_range(0, 15) == 0), 6'b0, 1'($urandom), 8'($urandom_range(0, DEPTH)),
                          ($urandom_range(0, 15) == 0), 6'b0, 1'($urandom), 8'($urandom_range(0, DEPTH))};
        if (ph[0] == 0)
          drv(we, $urandom_range(0, 5) == 0, a, wd, $urandom_range(0, 4) == 0,
              $urandom_range(0, 4) != 0, 8'($urandom), $urandom_range(0, 20) == 0);
        else
          drv(we || a == 4, $urandom_range(0, 1) == 0, a, wd, $urandom_range(0, 4) != 0,
              $urandom_range(0, 4) == 0, 8'($urandom), $urandom_range(0, 20) == 0);
      end
    end
    idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule